// File: doc/BRIEF.md
# Byte-Stream to Word-Program Sequencer

This block sits in front of a flash controller that can only program whole, aligned 32-bit words. A request gives a byte address, a byte count and a stream of bytes. The block cuts the range into aligned words and packs the incoming bytes little-endian. Lanes of a word that the request does not cover are filled with the bytes already stored in the array. The block reads the current word before it builds each new word.

Flash bits can only be cleared by programming. For this reason, every assembled word is compared with the stored word before a program command is sent. A word that would need any bit raised from 0 to 1 stops the request with a not-erased status. Words are issued one at a time. After each command the block waits for the controller's busy flag to drop, and a cycle limit bounds that wait. A controller error, an expired wait or a failed erase check ends the request at once. A request with zero bytes finishes in the next cycle and issues nothing.

Top module: `bytewise_prog_seq`

## Requirements
- R1: The first word addressed is the start address with its two low bits cleared. Each following word is 4 bytes higher. Every `prog_addr` has bits [1:0] equal to 0.
- R2: Byte k of the stream lands in lane (start_addr + k) mod 4 of its word. Lane i occupies bits 8i+7..8i of `prog_word`.
- R3: In the first word, lanes below start_addr[1:0] keep the stored array bytes. If the count runs out before lane 3 is reached, the upper lanes also keep the stored bytes.
- R4: Between the first and the last word, each word takes four new bytes.
- R5: A partial last word takes the remaining new bytes in its low lanes. Its upper lanes keep the stored bytes.
- R6: A word is programmed only if (stored AND new) equals new. Otherwise no command is issued for it, and the request ends with status 1 (not erased).
- R7: At most one command is outstanding. The next word's command comes only after `ctl_busy` has been seen low after the previous command.
- R8: If `ctl_busy` stays high for more than `wait_limit` cycles after a command, the request ends with status 2 (timeout) and no further command is issued.
- R9: If `ctl_err` is high when `ctl_busy` drops, the request ends with status 3 (controller error) and no further command is issued.
- R10: A start with `byte_count` = 0 gives `done` in the next cycle with status 0. It consumes no bytes and issues no command.
- R11: `done` is a single-cycle pulse. `status` is 0 when every word was programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request, sampled while idle |
| start_addr | input | ADDR_W | Byte address of the first byte |
| byte_count | input | CNT_W | Number of bytes in the request |
| in_valid | input | 1 | A stream byte is offered |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| arr_rd_en | output | 1 | Read the stored word (data one cycle later) |
| arr_rd_addr | output | ADDR_W | Word-aligned read address |
| arr_rd_word | input | 32 | Stored word returned by the array |
| prog_valid | output | 1 | One-cycle word-program command |
| prog_addr | output | ADDR_W | Aligned address of the word to program |
| prog_word | output | 32 | Word value to program |
| ctl_busy | input | 1 | Controller is still programming |
| ctl_err | input | 1 | Controller error, sampled when busy drops |
| wait_limit | input | TMO_W | Busy-wait cycle limit per word |
| seq_busy | output | 1 | A request is in progress |
| done | output | 1 | Request finished (one cycle) |
| status | output | 2 | 0 ok, 1 not erased, 2 timeout, 3 controller error |

## Verification
The bench uses ADDR_W = 8, which gives a 64-word array model that the bench can hold in full and compare against. CNT_W = 8 and TMO_W = 8 keep requests short and let a `wait_limit` of 5 reach the timeout path within a few cycles. With these values, single-word head cases, three-word head/middle/tail spans, a zero count, a pre-programmed word that fails the erase check, a stuck controller and a controller error can all be run in a short test.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        SEQ_OK          = 2'd0,
        SEQ_NOT_ERASED  = 2'd1,
        SEQ_TIMEOUT     = 2'd2,
        SEQ_CTL_ERR     = 2'd3
    } seq_status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_CAPTURE,
        PH_FILL,
        PH_CHECK,
        PH_ISSUE,
        PH_WAIT
    } seq_phase_e;

    // Programming can only clear bits: new word must be a subset of stored word.
    function automatic logic can_program(input logic [WORD_W-1:0] stored,
                                         input logic [WORD_W-1:0] wanted);
        return (stored & wanted) == wanted;
    endfunction
endpackage

// File: rtl/bwp_lane_merge.sv
module bwp_lane_merge
    import bwp_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [1:0]        lane,
    input  logic [BYTE_W-1:0] new_byte,
    output logic [WORD_W-1:0] word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_out[g*BYTE_W +: BYTE_W] =
            (lane == g[1:0]) ? new_byte : word_in[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/bwp_wait_timer.sv
module bwp_wait_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/bytewise_prog_seq.sv
module bytewise_prog_seq
    import bwp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              arr_rd_en,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [31:0]       arr_rd_word,
    output logic              prog_valid,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [31:0]       prog_word,
    input  logic              ctl_busy,
    input  logic              ctl_err,
    input  logic [TMO_W-1:0]  wait_limit,
    output logic              seq_busy,
    output logic              done,
    output logic [1:0]        status
);
    localparam int LANE_W = $clog2(LANES);

    seq_phase_e         phase_q;
    logic [ADDR_W-1:0]  waddr_q;
    logic [LANE_W-1:0]  lane_q;
    logic [CNT_W-1:0]   remain_q;
    logic [WORD_W-1:0]  old_q;
    logic [WORD_W-1:0]  cur_q;
    logic [WORD_W-1:0]  merged;
    logic               done_q;
    seq_status_e        status_q;
    logic               tmo_hit;

    bwp_lane_merge u_merge (
        .word_in  (cur_q),
        .lane     (lane_q),
        .new_byte (in_byte),
        .word_out (merged)
    );

    bwp_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (phase_q == PH_WAIT && ctl_busy),
        .limit   (wait_limit),
        .expired (tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            waddr_q  <= '0;
            lane_q   <= '0;
            remain_q <= '0;
            old_q    <= '0;
            cur_q    <= '0;
            done_q   <= 1'b0;
            status_q <= SEQ_OK;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        if (byte_count == '0) begin
                            done_q   <= 1'b1;
                            status_q <= SEQ_OK;
                        end else begin
                            waddr_q  <= {start_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                            lane_q   <= start_addr[LANE_W-1:0];
                            remain_q <= byte_count;
                            phase_q  <= PH_READ;
                        end
                    end
                end
                PH_READ: phase_q <= PH_CAPTURE;
                PH_CAPTURE: begin
                    old_q   <= arr_rd_word;
                    cur_q   <= arr_rd_word;
                    phase_q <= PH_FILL;
                end
                PH_FILL: begin
                    if (in_valid) begin
                        cur_q    <= merged;
                        remain_q <= remain_q - 1'b1;
                        lane_q   <= lane_q + 1'b1;
                        if (lane_q == LANE_W'(LANES - 1) || remain_q == CNT_W'(1)) begin
                            phase_q <= PH_CHECK;
                        end
                    end
                end
                PH_CHECK: begin
                    if (can_program(old_q, cur_q)) begin
                        phase_q <= PH_ISSUE;
                    end else begin
                        done_q   <= 1'b1;
                        status_q <= SEQ_NOT_ERASED;
                        phase_q  <= PH_IDLE;
                    end
                end
                PH_ISSUE: phase_q <= PH_WAIT;
                PH_WAIT: begin
                    if (!ctl_busy) begin
                        if (ctl_err) begin
                            done_q   <= 1'b1;
                            status_q <= SEQ_CTL_ERR;
                            phase_q  <= PH_IDLE;
                        end else if (remain_q == '0) begin
                            done_q   <= 1'b1;
                            status_q <= SEQ_OK;
                            phase_q  <= PH_IDLE;
                        end else begin
                            waddr_q <= waddr_q + ADDR_W'(LANES);
                            lane_q  <= '0;
                            phase_q <= PH_READ;
                        end
                    end else if (tmo_hit) begin
                        done_q   <= 1'b1;
                        status_q <= SEQ_TIMEOUT;
                        phase_q  <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign in_ready    = (phase_q == PH_FILL);
    assign arr_rd_en   = (phase_q == PH_READ);
    assign arr_rd_addr = waddr_q;
    assign prog_valid  = (phase_q == PH_ISSUE);
    assign prog_addr   = waddr_q;
    assign prog_word   = cur_q;
    assign seq_busy    = (phase_q != PH_IDLE);
    assign done        = done_q;
    assign status      = status_q;
endmodule

// File: rtl/bwp_seq_checker.sv
module bwp_seq_checker #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  byte_count,
    input logic              seq_busy,
    input logic              prog_valid,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [31:0]       prog_word,
    input logic [31:0]       stored_word,
    input logic              done,
    input logic [1:0]        status
);
    AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        prog_valid |-> (prog_addr[1:0] == 2'b00)); // R1

    AST_CMD_ERASED: assert property (@(posedge clk) disable iff (rst)
        prog_valid |-> ((prog_word & stored_word) == prog_word)); // R6

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        prog_valid |=> !prog_valid); // R7

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (start && !seq_busy && byte_count == '0) |=> (done && status == 2'd0)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
endmodule

bind bytewise_prog_seq bwp_seq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .byte_count  (byte_count),
    .seq_busy    (seq_busy),
    .prog_valid  (prog_valid),
    .prog_addr   (prog_addr),
    .prog_word   (prog_word),
    .stored_word (old_q),
    .done        (done),
    .status      (status)
);

// File: tb/sim_bytewise_prog_seq.sv
module sim_bytewise_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          in_ready;
    logic          arr_rd_en;
    logic [AW-1:0] arr_rd_addr;
    logic [31:0]   arr_rd_word = '0;
    logic          prog_valid;
    logic [AW-1:0] prog_addr;
    logic [31:0]   prog_word;
    logic          ctl_busy = 1'b0;
    logic          ctl_err = 1'b0;
    logic [TW-1:0] wait_limit = 8'd40;
    logic          seq_busy;
    logic          done;
    logic [1:0]    status;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytewise_prog_seq #(.ADDR_W(AW), .CNT_W(CW), .TMO_W(TW)) u0 (.*);

    typedef struct { logic [AW-1:0] a; logic [31:0] w; string req; } exp_cmd_t;
    exp_cmd_t   exp_cmds[$];
    int         exp_st[$];
    string      exp_st_req[$];
    logic [7:0] src_q[$];
    logic [31:0] mem [64];

    int n_cmp = 0;
    int n_bad = 0;
    int n_done = 0;
    int cycles = 0;

    int  c_delay = 3;
    bit  c_hang = 1'b0;
    bit  c_inject = 1'b0;
    int  c_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // array read port: one-cycle latency
    always @(posedge clk) if (arr_rd_en) arr_rd_word <= mem[arr_rd_addr[7:2]];

    // controller model
    always @(posedge clk) begin
        if (rst) begin
            ctl_busy <= 1'b0; ctl_err <= 1'b0; c_cnt <= 0;
        end else if (prog_valid) begin
            ctl_busy <= 1'b1; ctl_err <= 1'b0; c_cnt <= c_delay;
            mem[prog_addr[7:2]] <= mem[prog_addr[7:2]] & prog_word;
        end else if (ctl_busy && !c_hang) begin
            if (c_cnt <= 1) begin
                ctl_busy <= 1'b0; ctl_err <= c_inject;
            end else begin
                c_cnt <= c_cnt - 1;
            end
        end
    end

    // byte source
    always @(posedge clk) if (in_valid && in_ready && src_q.size() > 0) void'(src_q.pop_front());
    always @(negedge clk) begin
        in_valid <= (src_q.size() > 0);
        in_byte  <= (src_q.size() > 0) ? src_q[0] : 8'h00;
    end

    // monitor: compares design outputs with scoreboard queues
    always @(negedge clk) begin
        if (!rst) begin
            if (prog_valid) begin
                if (exp_cmds.size() == 0) begin
                    chk(1'b0, "R7", "unexpected command addr", longint'(prog_addr), 0);
                end else begin
                    exp_cmd_t e;
                    e = exp_cmds.pop_front();
                    chk(prog_addr == e.a, e.req, "command addr", longint'(prog_addr), longint'(e.a));
                    chk(prog_word == e.w, e.req, "command word", longint'(prog_word), longint'(e.w));
                end
            end
            if (done) begin
                n_done++;
                if (exp_st.size() == 0) begin
                    chk(1'b0, "R11", "unexpected done status", longint'(status), 0);
                end else begin
                    int s;
                    string r;
                    s = exp_st.pop_front();
                    r = exp_st_req.pop_front();
                    chk(status == 2'(s), r, "final status", longint'(status), longint'(s));
                end
            end
        end
    end

    // driver: computes expected words from a byte view of the array model
    task automatic run_req(input int a, input int n, input int seed, input int keep_cmds,
                           input int force_st, input string req);
        int   st;
        int   ncmd;
        int   seen;
        int   wait_c;
        logic [7:0] b[$];
        st = 0;
        ncmd = 0;
        for (int k = 0; k < n; k++) b.push_back(8'((seed + k * 37) & 255));
        if (n > 0) begin
            for (int w = a & ~3; w <= ((a + n - 1) & ~3); w += 4) begin
                logic [31:0] nv;
                nv = mem[w >> 2];
                for (int l = 0; l < 4; l++) begin
                    if (w + l >= a && w + l < a + n) nv[8*l +: 8] = b[w + l - a];
                end
                if ((mem[w >> 2] & nv) != nv) begin
                    st = 1;
                    break;
                end
                if (keep_cmds < 0 || ncmd < keep_cmds) begin
                    exp_cmd_t e;
                    e.a = AW'(w); e.w = nv; e.req = req;
                    exp_cmds.push_back(e);
                    ncmd++;
                end
            end
        end
        if (force_st >= 0) st = force_st;
        exp_st.push_back(st);
        exp_st_req.push_back(req);
        foreach (b[k]) src_q.push_back(b[k]);
        seen = n_done;
        @(negedge clk);
        start = 1'b1; start_addr = AW'(a); byte_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
        wait_c = 0;
        while (n_done == seen && wait_c < 500) begin
            @(negedge clk);
            wait_c++;
        end
        chk(n_done != seen, req, "done seen", longint'(n_done - seen), 1);
        repeat (2) @(negedge clk);
        chk(exp_cmds.size() == 0, req, "commands left unissued", longint'(exp_cmds.size()), 0);
        exp_cmds.delete();
        c_hang = 1'b0;
        repeat (c_delay + 4) @(negedge clk);
        src_q.delete();
        c_inject = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!done && !seq_busy && !prog_valid && !in_ready, "R11", "idle after reset",
            longint'({done, seq_busy, prog_valid, in_ready}), 0);

        // R2 R4: aligned, two full words
        run_req(8'h10, 8, 5, -1, -1, "R4");
        // R3: unaligned head inside one word, upper lane kept
        run_req(8'h21, 2, 9, -1, -1, "R3");
        chk(mem[8'h20 >> 2][31:24] == 8'hFF && mem[8'h20 >> 2][7:0] == 8'hFF, "R3",
            "untouched lanes of head word", longint'(mem[8'h20 >> 2]), 0);
        // R1 R2 R5: head, middle and tail words
        run_req(8'h31, 9, 20, -1, -1, "R1");
        // R5: aligned start with partial tail
        run_req(8'h70, 6, 77, -1, -1, "R5");
        // R10: zero count
        run_req(8'h45, 0, 0, -1, -1, "R10");
        chk(src_q.size() == 0 && !seq_busy, "R10", "idle after zero count", longint'(seq_busy), 0);
        // R6: stored word already has cleared bits
        mem[8'h40 >> 2] = 32'h0000_FFFF;
        run_req(8'h40, 4, 1, -1, -1, "R6");
        chk(mem[8'h40 >> 2] == 32'h0000_FFFF, "R6", "word untouched", longint'(mem[8'h40 >> 2]), 32'h0000_FFFF);
        // R8: controller stuck busy
        wait_limit = 8'd5;
        c_hang = 1'b1;
        run_req(8'h50, 8, 3, 1, 2, "R8");
        wait_limit = 8'd40;
        // R9: controller error on first word
        c_inject = 1'b1;
        run_req(8'h60, 8, 11, 1, 3, "R9");
        // R7: slow controller, three words still in order
        c_delay = 12;
        run_req(8'h82, 10, 50, -1, -1, "R7");
        c_delay = 3;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule